// File: doc/BRIEF.md
# Packed-Symbol Error Applier

This block sits after a Reed-Solomon error locator whose code works on 12-bit symbols packed back to back over a page buffer. The buffer holds 2048 data bytes and is followed, in the same byte address space, by spare bytes at addresses 2048 and up. The locator hands over one report at a time: a symbol position and a 12-bit error pattern. The block turns each report into one or two byte addresses with XOR masks and updates the buffer through a single synchronous RAM port, one read followed by one write per byte.

Because two symbols cover three bytes, an odd symbol starts on a byte boundary while an even one ends on it. Position 0 has only its low byte backed by data, and position 1365 crosses from the last data byte into the first spare byte. Reports that cannot be applied mark the page as failed, and from then on nothing is written until the next page begins. Two counters track applied symbols and failed pages. The block also splits four 32-bit syndrome words into eight 12-bit syndromes and brings out the "correction needed" flag of a status word, for use by the locator.

Top module: `symfix_applier`

## Requirements
- R1: Syndrome word k (k = 0..3, taken from `syn_words[32k+31:32k]`) supplies syndrome 2k from its bits 11:0 and syndrome 2k+1 from its bits 27:16; syndrome j appears at `syn_flat[12j+11:12j]`.
- R2: `need_fix` equals bit 18 of `ecc_status`, whatever the other bits are.
- R3: For an odd position p up to 1374, with b = floor(3p/2), byte b is XORed with pattern bits 11:4 and byte b+1 with pattern bits 3:0 placed in bits 7:4 of the mask.
- R4: For a nonzero even position p up to 1374, with b = 3p/2, byte b-1 is XORed with pattern bits 11:8 (as a mask 0000pppp) and byte b with pattern bits 7:0.
- R5: At position 0 with a pattern of at most 0xFF, only byte 0 is changed, XORed with the pattern; a pattern above 0xFF is uncorrectable.
- R6: Position 1365 XORs data byte 2047 with pattern bits 11:4 and spare byte 0 (address 2048) with pattern bits 3:0 shifted into bits 7:4.
- R7: Positions 1366 to 1374 update spare bytes with the same odd/even rules, spare byte n being buffer address 2048+n; position 1374 touches addresses 2060 and 2061.
- R8: A position above 1374 is uncorrectable and changes no byte.
- R9: Once a report of the current page is uncorrectable, `page_fail` is 1 and no report (that one included) writes the buffer until `page_start`.
- R10: `fixed_count` adds one for each applied report; `fail_count` adds one when a page first becomes failed, not for later bad reports in the same page. Both are 0 after reset.
- R11: Each byte update is a read cycle then a write cycle at the same address, the written value being the read value XOR the mask; `rpt_ready` is low while an update runs (4 cycles for two bytes, 2 for one), and a report held valid meanwhile is taken only when `rpt_ready` returns.
- R12: A `page_start` pulse clears `page_fail`; a report in the same cycle already belongs to the new page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_status | input | 32 | Status word from the syndrome engine |
| need_fix | output | 1 | Correction-needed flag taken from the status word |
| syn_words | input | 128 | Four packed syndrome words |
| syn_flat | output | 96 | Eight unpacked 12-bit syndromes |
| page_start | input | 1 | Pulse marking the start of a new page |
| rpt_valid | input | 1 | Error report present |
| rpt_ready | output | 1 | Block can take a report |
| rpt_pos | input | 12 | Symbol position of the report |
| rpt_pat | input | 12 | Error pattern of the report |
| mem_addr | output | 12 | Buffer byte address |
| mem_rd_en | output | 1 | Buffer read strobe (data one cycle later) |
| mem_wr_en | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after `mem_rd_en` |
| page_fail | output | 1 | Current page is uncorrectable |
| fixed_count | output | 16 | Applied report count |
| fail_count | output | 16 | Failed page count |

## Verification
Reports are sent at an odd and an even position well inside the data area, at position 0 with a small and a large pattern, at the straddling position 1365, and at odd and even spare positions up to 1374, using patterns whose nibbles differ so that a swapped nibble, a wrong shift or an off-by-one byte each show up as a different wrong byte. Bytes beside the touched ones are checked unchanged and the whole buffer is compared with a model after each group. Out-of-range and oversized-pattern reports are followed by good reports in the same page to show writes stay blocked, and a page restart shows they resume and that the failed-page count rises once per page. A report held valid across a running update shows back-pressure, and the busy length distinguishes one-byte from two-byte updates.

// File: rtl/symfix_pkg.sv
// Shared definitions for the packed-symbol error applier.
// Assumes 12-bit symbols and byte-wide buffer access.
package symfix_pkg;
    localparam int SYM_W  = 12;
    localparam int BYTE_W = 8;

    // Sequencer phases: read and write for the first byte, then the second.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RD0  = 3'd1,
        PH_WR0  = 3'd2,
        PH_RD1  = 3'd3,
        PH_WR1  = 3'd4
    } phase_t;
endpackage

// File: rtl/symfix_syn_unpack.sv
// Splits packed syndrome words into 12-bit syndromes and extracts the
// correction-needed flag. Purely combinational; assumes two syndromes per
// 32-bit word in bits 11:0 and 27:16.
module symfix_syn_unpack #(
    parameter int WORDS = 4,
    parameter int FLAG_BIT = 18
) (
    input  logic [32*WORDS-1:0]                   syn_words,
    input  logic [31:0]                           ecc_status,
    output logic [2*WORDS*symfix_pkg::SYM_W-1:0]  syn_flat,
    output logic                                  need_fix
);
    import symfix_pkg::*;

    logic [2*WORDS-1:0] spare_hi;
    logic               unused_bits;

    // One word yields two syndromes.
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign syn_flat[(2*k)*SYM_W +: SYM_W]   = syn_words[32*k +: SYM_W];
        assign syn_flat[(2*k+1)*SYM_W +: SYM_W] = syn_words[32*k+16 +: SYM_W];
        assign spare_hi[2*k]   = ^syn_words[32*k+12 +: 4];
        assign spare_hi[2*k+1] = ^syn_words[32*k+28 +: 4];
    end

    // Status flag pick-off.
    assign need_fix = ecc_status[FLAG_BIT];

    // Bits that carry no syndrome information are folded away.
    assign unused_bits = ^{spare_hi, ecc_status};
endmodule

// File: rtl/symfix_pos_map.sv
// Maps a symbol position and pattern to byte addresses and XOR masks.
// Assumes the data and spare areas share one flat byte address space, so
// the same odd/even formula covers the straddle and the spare area.
module symfix_pos_map #(
    parameter int ADDR_W  = 12,
    parameter int MAX_POS = 1374
) (
    input  logic [symfix_pkg::SYM_W-1:0] pos,
    input  logic [symfix_pkg::SYM_W-1:0] pat,
    output logic                         bad,
    output logic                         two,
    output logic [ADDR_W-1:0]            addr0,
    output logic [ADDR_W-1:0]            addr1,
    output logic [symfix_pkg::BYTE_W-1:0] mask0,
    output logic [symfix_pkg::BYTE_W-1:0] mask1
);
    import symfix_pkg::*;

    logic [SYM_W+1:0] triple;
    logic [SYM_W:0]   half;
    logic             at_zero;

    // Byte offset of the symbol: floor(3p/2).
    always_comb begin
        triple = {2'b00, pos} + {1'b0, pos, 1'b0};
        half   = triple[SYM_W+1:1];
    end

    // Select the byte pair and masks for the symbol's alignment.
    always_comb begin
        at_zero = (pos == '0);
        bad     = (32'(pos) > MAX_POS) || (at_zero && (pat[11:8] != 4'h0));
        two     = !at_zero;
        if (at_zero) begin
            addr0 = '0;
            addr1 = '0;
            mask0 = pat[7:0];
            mask1 = '0;
        end else if (pos[0]) begin
            addr0 = ADDR_W'(half);
            addr1 = ADDR_W'(half + 1'b1);
            mask0 = pat[11:4];
            mask1 = {pat[3:0], 4'h0};
        end else begin
            addr0 = ADDR_W'(half - 1'b1);
            addr1 = ADDR_W'(half);
            mask0 = {4'h0, pat[11:8]};
            mask1 = pat[7:0];
        end
    end
endmodule

// File: rtl/symfix_seq.sv
// Accepts reports, runs read-then-write updates on the buffer port and
// tracks page failure and counters. Assumes the RAM returns read data one
// cycle after the read strobe.
module symfix_seq #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          page_start,
    input  logic                          rpt_valid,
    output logic                          rpt_ready,
    input  logic                          map_bad,
    input  logic                          map_two,
    input  logic [ADDR_W-1:0]             map_a0,
    input  logic [ADDR_W-1:0]             map_a1,
    input  logic [symfix_pkg::BYTE_W-1:0] map_m0,
    input  logic [symfix_pkg::BYTE_W-1:0] map_m1,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic                          mem_rd_en,
    output logic                          mem_wr_en,
    output logic [symfix_pkg::BYTE_W-1:0] mem_wdata,
    input  logic [symfix_pkg::BYTE_W-1:0] mem_rdata,
    output logic                          page_fail,
    output logic [CNT_W-1:0]              fixed_count,
    output logic [CNT_W-1:0]              fail_count
);
    import symfix_pkg::*;

    phase_t              phase;
    logic                two_q;
    logic [ADDR_W-1:0]   a0_q, a1_q;
    logic [BYTE_W-1:0]   m0_q, m1_q;
    logic                take;
    logic                live_fail;

    // Handshake and the failure state as seen by a report this cycle.
    always_comb begin
        rpt_ready = (phase == PH_IDLE);
        take      = rpt_valid && rpt_ready;
        live_fail = page_fail && !page_start;
    end

    // Phase machine, captured plan, page flag and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            two_q       <= 1'b0;
            a0_q        <= '0;
            a1_q        <= '0;
            m0_q        <= '0;
            m1_q        <= '0;
            page_fail   <= 1'b0;
            fixed_count <= '0;
            fail_count  <= '0;
        end else begin
            if (page_start) page_fail <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (take) begin
                        if (map_bad) begin
                            page_fail <= 1'b1;
                            if (!live_fail) fail_count <= fail_count + 1'b1;
                        end else if (!live_fail) begin
                            phase       <= PH_RD0;
                            two_q       <= map_two;
                            a0_q        <= map_a0;
                            a1_q        <= map_a1;
                            m0_q        <= map_m0;
                            m1_q        <= map_m1;
                            fixed_count <= fixed_count + 1'b1;
                        end
                    end
                end
                PH_RD0:  phase <= PH_WR0;
                PH_WR0:  phase <= two_q ? PH_RD1 : PH_IDLE;
                PH_RD1:  phase <= PH_WR1;
                PH_WR1:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // RAM port drive from the current phase.
    always_comb begin
        mem_rd_en = (phase == PH_RD0) || (phase == PH_RD1);
        mem_wr_en = (phase == PH_WR0) || (phase == PH_WR1);
        mem_addr  = ((phase == PH_RD0) || (phase == PH_WR0)) ? a0_q : a1_q;
        mem_wdata = mem_rdata ^ ((phase == PH_WR0) ? m0_q : m1_q);
    end

    // R11: a write always follows a read of the same address.
    assert_rmw_pairing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));

    // R11: the port never reads and writes together.
    assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R9: a failed page sees no buffer writes.
    assert_no_write_failed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        page_fail |-> !mem_wr_en);

    // R10: a new applied count is accompanied by the start of an update.
    assert_count_has_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_count != $past(fixed_count)) |-> (mem_rd_en && !rpt_ready));

    // R10: the failed-page count only moves when the page flag is set.
    assert_failcount_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count != $past(fail_count)) |-> page_fail);
endmodule

// File: rtl/symfix_applier.sv
// Top of the packed-symbol error applier: syndrome unpacking, position to
// byte mapping and the read-modify-write sequencer. Assumes a buffer of
// DATA_BYTES data bytes followed by SPARE_BYTES spare bytes.
module symfix_applier #(
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int MAX_POS     = 1374,
    parameter int SYN_WORDS   = 4,
    parameter int CNT_W       = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [31:0]                            ecc_status,
    output logic                                   need_fix,
    input  logic [32*SYN_WORDS-1:0]                syn_words,
    output logic [2*SYN_WORDS*symfix_pkg::SYM_W-1:0] syn_flat,
    input  logic                                   page_start,
    input  logic                                   rpt_valid,
    output logic                                   rpt_ready,
    input  logic [symfix_pkg::SYM_W-1:0]           rpt_pos,
    input  logic [symfix_pkg::SYM_W-1:0]           rpt_pat,
    output logic [$clog2(DATA_BYTES+SPARE_BYTES)-1:0] mem_addr,
    output logic                                   mem_rd_en,
    output logic                                   mem_wr_en,
    output logic [symfix_pkg::BYTE_W-1:0]          mem_wdata,
    input  logic [symfix_pkg::BYTE_W-1:0]          mem_rdata,
    output logic                                   page_fail,
    output logic [CNT_W-1:0]                       fixed_count,
    output logic [CNT_W-1:0]                       fail_count
);
    import symfix_pkg::*;

    localparam int ADDR_W = $clog2(DATA_BYTES + SPARE_BYTES);

    logic              map_bad, map_two;
    logic [ADDR_W-1:0] map_a0, map_a1;
    logic [BYTE_W-1:0] map_m0, map_m1;

    symfix_syn_unpack #(.WORDS(SYN_WORDS), .FLAG_BIT(18)) u_unpack (
        .syn_words (syn_words),
        .ecc_status(ecc_status),
        .syn_flat  (syn_flat),
        .need_fix  (need_fix)
    );

    symfix_pos_map #(.ADDR_W(ADDR_W), .MAX_POS(MAX_POS)) u_map (
        .pos  (rpt_pos),
        .pat  (rpt_pat),
        .bad  (map_bad),
        .two  (map_two),
        .addr0(map_a0),
        .addr1(map_a1),
        .mask0(map_m0),
        .mask1(map_m1)
    );

    symfix_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_start (page_start),
        .rpt_valid  (rpt_valid),
        .rpt_ready  (rpt_ready),
        .map_bad    (map_bad),
        .map_two    (map_two),
        .map_a0     (map_a0),
        .map_a1     (map_a1),
        .map_m0     (map_m0),
        .map_m1     (map_m1),
        .mem_addr   (mem_addr),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .page_fail  (page_fail),
        .fixed_count(fixed_count),
        .fail_count (fail_count)
    );
endmodule

// File: tb/symfix_applier_bench.sv
`timescale 1ns/1ps
// Directed bench for the packed-symbol error applier with a byte RAM model.
module symfix_applier_bench;
    localparam int NBYTES = 2112;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ecc_status = '0;
    logic        need_fix;
    logic [127:0] syn_words = '0;
    logic [95:0] syn_flat;
    logic        page_start = 1'b0;
    logic        rpt_valid = 1'b0;
    logic        rpt_ready;
    logic [11:0] rpt_pos = '0;
    logic [11:0] rpt_pat = '0;
    logic [11:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        page_fail;
    logic [15:0] fixed_count, fail_count;

    logic [7:0] ram [0:NBYTES-1];
    logic [7:0] expm [0:NBYTES-1];
    int errors = 0;
    int checks = 0;
    int busy_len = 0;
    bit done = 0;
    int exp_fixed = 0;
    int exp_failcnt = 0;
    bit exp_pfail = 0;

    always #10 clk = ~clk;

    symfix_applier u_symfix_applier (
        .clk(clk), .rst_n(rst_n), .ecc_status(ecc_status), .need_fix(need_fix),
        .syn_words(syn_words), .syn_flat(syn_flat), .page_start(page_start),
        .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_pos(rpt_pos),
        .rpt_pat(rpt_pat), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .page_fail(page_fail), .fixed_count(fixed_count), .fail_count(fail_count)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    // RAM model: registered read, write on strobe, filled during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) ram[i] <= init_val(i);
            mem_rdata <= '0;
        end else begin
            if (mem_rd_en) mem_rdata <= ram[mem_addr];
            if (mem_wr_en) ram[mem_addr] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // Expected effect of one report on the model.
    task automatic model_apply(input int p, input int pt);
        int b;
        if (p > 1374 || (p == 0 && pt > 255)) begin
            if (!exp_pfail) exp_failcnt++;
            exp_pfail = 1;
        end else if (!exp_pfail) begin
            exp_fixed++;
            b = (3 * p) / 2;
            if (p == 0) expm[0] ^= 8'(pt);
            else if (p % 2 == 1) begin
                expm[b]   ^= 8'(pt >> 4);
                expm[b+1] ^= 8'((pt << 4) & 255);
            end else begin
                expm[b-1] ^= 8'(pt >> 8);
                expm[b]   ^= 8'(pt & 255);
            end
        end
    endtask

    task automatic send(input int p, input int pt);
        @(negedge clk);
        while (!rpt_ready) @(negedge clk);
        rpt_valid = 1'b1;
        rpt_pos = 12'(p);
        rpt_pat = 12'(pt);
        @(negedge clk);
        rpt_valid = 1'b0;
        busy_len = 0;
        while (!rpt_ready) begin busy_len++; @(negedge clk); end
        model_apply(p, pt);
    endtask

    task automatic new_page();
        @(negedge clk);
        page_start = 1'b1;
        @(negedge clk);
        page_start = 1'b0;
        exp_pfail = 0;
    endtask

    task automatic compare_all(input string req);
        int bad_at = -1;
        for (int i = 0; i < NBYTES; i++)
            if (bad_at < 0 && ram[i] !== expm[i]) bad_at = i;
        if (bad_at < 0) check(1'b1, req, 0, 0);
        else check(1'b0, {req, " buffer"}, int'(ram[bad_at]), int'(expm[bad_at]));
    endtask

    task automatic t_reset();
        check(rpt_ready === 1'b1, "R11 ready after reset", int'(rpt_ready), 1);
        check(page_fail === 1'b0, "R9 flag after reset", int'(page_fail), 0);
        check(fixed_count === 16'd0, "R10 fixed count reset", int'(fixed_count), 0);
        check(fail_count === 16'd0, "R10 fail count reset", int'(fail_count), 0);
        check(mem_wr_en === 1'b0, "R11 no write at reset", int'(mem_wr_en), 0);
    endtask

    task automatic t_unpack();
        syn_words = {32'hF9AB_FCDE, 32'h1123_2456, 32'hA789_B0AB, 32'h5FED_6CBA};
        ecc_status = 32'h0004_0000;
        #1;
        check(syn_flat[11:0]  === 12'hCBA, "R1 syndrome 0", int'(syn_flat[11:0]), 'hCBA);
        check(syn_flat[23:12] === 12'hFED, "R1 syndrome 1", int'(syn_flat[23:12]), 'hFED);
        check(syn_flat[35:24] === 12'h0AB, "R1 syndrome 2", int'(syn_flat[35:24]), 'h0AB);
        check(syn_flat[59:48] === 12'h456, "R1 syndrome 4", int'(syn_flat[59:48]), 'h456);
        check(syn_flat[95:84] === 12'h9AB, "R1 syndrome 7", int'(syn_flat[95:84]), 'h9AB);
        check(need_fix === 1'b1, "R2 flag set", int'(need_fix), 1);
        ecc_status = 32'hFFFB_FFFF;
        #1;
        check(need_fix === 1'b0, "R2 flag clear", int'(need_fix), 0);
    endtask

    task automatic t_odd();
        send(1, 'hABC);
        check(busy_len == 4, "R11 two-byte busy", busy_len, 4);
        check(ram[1] === (init_val(1) ^ 8'hAB), "R3 odd first byte", int'(ram[1]), int'(init_val(1) ^ 8'hAB));
        check(ram[2] === (init_val(2) ^ 8'hC0), "R3 odd second byte", int'(ram[2]), int'(init_val(2) ^ 8'hC0));
        check(ram[0] === init_val(0), "R3 neighbour below", int'(ram[0]), int'(init_val(0)));
        send(101, 'h5E3);
        compare_all("R3");
    endtask

    task automatic t_even();
        send(4, 'hABC);
        check(ram[5] === (init_val(5) ^ 8'h0A), "R4 even first byte", int'(ram[5]), int'(init_val(5) ^ 8'h0A));
        check(ram[6] === (init_val(6) ^ 8'hBC), "R4 even second byte", int'(ram[6]), int'(init_val(6) ^ 8'hBC));
        check(ram[7] === init_val(7), "R4 neighbour above", int'(ram[7]), int'(init_val(7)));
        send(1364, 'h7D2);
        compare_all("R4");
    endtask

    task automatic t_zero();
        send(0, 'h05A);
        check(busy_len == 2, "R11 one-byte busy", busy_len, 2);
        check(ram[0] === (init_val(0) ^ 8'h5A), "R5 byte zero", int'(ram[0]), int'(init_val(0) ^ 8'h5A));
        check(page_fail === 1'b0, "R5 small pattern ok", int'(page_fail), 0);
    endtask

    task automatic t_straddle();
        send(1365, 'h9E7);
        check(ram[2047] === (init_val(2047) ^ 8'h9E), "R6 last data byte", int'(ram[2047]), int'(init_val(2047) ^ 8'h9E));
        check(ram[2048] === (init_val(2048) ^ 8'h70), "R6 first spare byte", int'(ram[2048]), int'(init_val(2048) ^ 8'h70));
    endtask

    task automatic t_spare();
        send(1374, 'h123);
        check(ram[2060] === (init_val(2060) ^ 8'h01), "R7 last pos byte a", int'(ram[2060]), int'(init_val(2060) ^ 8'h01));
        check(ram[2061] === (init_val(2061) ^ 8'h23), "R7 last pos byte b", int'(ram[2061]), int'(init_val(2061) ^ 8'h23));
        send(1367, 'hFFF);
        check(ram[2050] === (init_val(2050) ^ 8'hFF), "R7 odd spare a", int'(ram[2050]), int'(init_val(2050) ^ 8'hFF));
        check(ram[2051] === (init_val(2051) ^ 8'hF0), "R7 odd spare b", int'(ram[2051]), int'(init_val(2051) ^ 8'hF0));
        compare_all("R7");
        check(int'(fixed_count) == exp_fixed, "R10 applied count", int'(fixed_count), exp_fixed);
    endtask

    task automatic t_range();
        new_page();
        send(1375, 'h111);
        check(page_fail === 1'b1, "R8 out of range flags", int'(page_fail), 1);
        check(int'(fail_count) == 1, "R10 one failed page", int'(fail_count), 1);
        compare_all("R8");
        send(5, 'h777);
        check(ram[7] === expm[7], "R9 blocked write", int'(ram[7]), int'(expm[7]));
        send(0, 'h100);
        check(int'(fail_count) == 1, "R10 once per page", int'(fail_count), 1);
        check(int'(fixed_count) == exp_fixed, "R10 no count when failed", int'(fixed_count), exp_fixed);
        compare_all("R9");
    endtask

    task automatic t_restart();
        new_page();
        check(page_fail === 1'b0, "R12 flag cleared", int'(page_fail), 0);
        send(0, 'h1FF);
        check(page_fail === 1'b1, "R5 large pattern flags", int'(page_fail), 1);
        check(int'(fail_count) == 2, "R10 second failed page", int'(fail_count), 2);
        new_page();
        send(3, 'h456);
        check(ram[4] === (init_val(4) ^ 8'h45), "R12 write resumes a", int'(ram[4]), int'(init_val(4) ^ 8'h45));
        check(ram[5] === expm[5], "R12 write resumes b", int'(ram[5]), int'(expm[5]));
        // R12: page start together with a report counts it in the new page.
        send(2000, 'h001);
        check(page_fail === 1'b1, "R12 setup fail", int'(page_fail), 1);
        @(negedge clk);
        page_start = 1'b1;
        rpt_valid = 1'b1;
        rpt_pos = 12'd9;
        rpt_pat = 12'h3C5;
        @(negedge clk);
        page_start = 1'b0;
        rpt_valid = 1'b0;
        exp_pfail = 0;
        while (!rpt_ready) @(negedge clk);
        model_apply(9, 'h3C5);
        compare_all("R12 same-cycle report");
    endtask

    task automatic t_hold();
        int seen;
        @(negedge clk);
        while (!rpt_ready) @(negedge clk);
        rpt_valid = 1'b1;
        rpt_pos = 12'd21;
        rpt_pat = 12'hA5F;
        @(negedge clk);
        rpt_pos = 12'd40;
        rpt_pat = 12'h6B2;
        seen = 0;
        while (!rpt_ready) begin seen++; @(negedge clk); end
        check(seen == 4, "R11 held report waits", seen, 4);
        @(negedge clk);
        rpt_valid = 1'b0;
        while (!rpt_ready) @(negedge clk);
        model_apply(21, 'hA5F);
        model_apply(40, 'h6B2);
        compare_all("R11 back-pressure");
        check(int'(fixed_count) == exp_fixed, "R10 final count", int'(fixed_count), exp_fixed);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) expm[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unpack();
        t_odd();
        t_even();
        t_zero();
        t_straddle();
        t_spare();
        t_range();
        t_restart();
        t_hold();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule